// File: doc/BRIEF.md
# Base-16 Floating-Point Restoring Divider

This block divides one single-precision base-16 floating-point word by another. A word holds a sign bit (bit 31), a seven-bit exponent (bits 30:24) that is a power of sixteen stored with an excess of 64, and a 24-bit fraction (bits 23:0) read as six hexadecimal digits after the point. Operands may arrive unnormalized. The block normalizes them internally before it divides.

A caller presents both operands and a rounding choice, then raises `start` for one clock while the block is idle. The block first settles the sign and the exponent of the quotient. It then builds the six quotient digits one at a time. Each digit is the number of times the divisor can be subtracted from the running remainder, and the block performs at most one subtraction per clock. When the result is ready, `done` pulses for one clock. The result word and the condition code are valid from that cycle and stay until the next result. `wr_en` rises alongside `done` whenever the result should be written back.

The condition code `cc` has four bits: bit 3 carry (C), bit 2 overflow/exception (V), bit 1 greater than zero (G) and bit 0 less than zero (L).

Top module: `hexdiv_fp_divider`

## Requirements
- R1: A divisor whose fraction field is zero gives `cc` = 4'b1100 (C and V), quotient 0 and `wr_en` low, with `done` pulsed.
- R2: A dividend whose fraction field is zero (and a nonzero divisor) gives quotient 32'h0, `cc` = 4'b0000 and `wr_en` high.
- R3: Otherwise both fractions are normalized until their top hex digit is nonzero, lowering each exponent by one per digit shifted. The sign is the XOR of the operand signs. The exponent is e1 - e2 + 64, plus one when the normalized dividend fraction is not below the divisor fraction. The fraction is the truncated six-digit quotient. `cc` is 4'b0010 for a positive result and 4'b0001 for a negative one.
- R4: If e1 - e2 + 64 is below 0, the result is quotient 0 with `cc` = 4'b0100 and `wr_en` high.
- R5: If the exponent exceeds 127, whether before or after the one-step adjustment, the result is sign followed by 31 ones, with `cc` = 4'b0110 (positive) or 4'b0101 (negative) and `wr_en` high.
- R6: With `round_en` high, one is added to the fraction when twice the final remainder is at least the normalized divisor fraction; a carry out of the fraction shifts it right by one digit and raises the exponent. With `round_en` low, the quotient is truncated.
- R7: Every nonexceptional nonzero quotient has a nonzero top hex digit (bits 23:20).
- R8: Each accepted `start` yields exactly one single-cycle `done` pulse within 100 clocks. `wr_en` is never high without `done`.
- R9: A `start` that arrives while a division is in progress is ignored, and the running result is unaffected.
- R10: While reset is asserted, `quotient`, `cc`, `wr_en` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division when idle |
| dividend | input | 32 | Dividend word (sign, excess-64 exponent, hex fraction) |
| divisor | input | 32 | Divisor word, same format |
| round_en | input | 1 | Round the quotient from the final remainder |
| quotient | output | 32 | Result word, held until the next result |
| cc | output | 4 | Condition code {C, V, G, L} |
| wr_en | output | 1 | Result should be written back (pulses with done) |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions take for granted that `dividend`, `divisor` and `round_en` hold known values on any edge where `start` is high in the idle state. They need no stability after that edge, because the block captures everything it needs at that moment. The digit-bound and normalization checks rely on the internal normalization stage, so operands with zero leading digits are fed on purpose rather than avoided. The bench drives every input at the falling edge and holds `start` for one cycle per operation. It issues exactly one extra `start` in the middle of a division, as the deliberate probe of R9.

// File: rtl/hexdiv_pkg.sv
package hexdiv_pkg;

  // Condition code bit positions
  localparam int CC_C = 3;
  localparam int CC_V = 2;
  localparam int CC_G = 1;
  localparam int CC_L = 0;

  typedef enum logic [1:0] {
    K_NORM = 2'd0,
    K_ZERO = 2'd1,
    K_DIVZ = 2'd2
  } res_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SUB  = 2'd1,
    S_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/hexdiv_unpack.sv
// Splits a word into sign, widened signed exponent and fraction, and
// normalizes the fraction one hex digit at a time.
module hexdiv_unpack #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7,
  parameter int XW     = EXP_W + 3
) (
  input  logic [FRAC_W+EXP_W:0]  word,
  output logic                   sgn,
  output logic signed [XW-1:0]   exp,
  output logic [FRAC_W-1:0]      frac,
  output logic                   is_zero
);
  localparam int W   = FRAC_W + EXP_W + 1;
  localparam int NIB = FRAC_W / 4;

  logic [FRAC_W-1:0]    f_n;
  logic signed [XW-1:0] e_n;

  always_comb begin
    f_n = word[FRAC_W-1:0];
    e_n = $signed({{(XW-EXP_W){1'b0}}, word[W-2 -: EXP_W]});
    for (int i = 0; i < NIB - 1; i++) begin
      if (f_n[FRAC_W-1 -: 4] == 4'h0) begin
        f_n = f_n << 4;
        e_n = e_n - XW'(1);
      end
    end
    is_zero = (word[FRAC_W-1:0] == '0);
    sgn     = is_zero ? 1'b0 : word[W-1];
    exp     = is_zero ? '0 : e_n;
    frac    = f_n;
  end

endmodule

// File: rtl/hexdiv_pack.sv
// Applies rounding, then range checks and packs the result word and code.
module hexdiv_pack
  import hexdiv_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7,
  parameter int XW     = EXP_W + 3
) (
  input  res_kind_e             kind,
  input  logic                  sgn,
  input  logic signed [XW-1:0]  exp,
  input  logic [FRAC_W-1:0]     frac,
  input  logic                  rnd_inc,
  output logic [FRAC_W+EXP_W:0] word,
  output logic [3:0]            cc,
  output logic                  wr
);
  localparam int W = FRAC_W + EXP_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] EMAX_S = XW'(EXP_MAX);

  logic [FRAC_W:0]      sum;
  logic [FRAC_W-1:0]    f2;
  logic signed [XW-1:0] e2;

  always_comb begin
    sum = {1'b0, frac} + (FRAC_W+1)'(rnd_inc);
    f2  = sum[FRAC_W-1:0];
    e2  = exp;
    if (sum[FRAC_W]) begin
      f2 = FRAC_W'(sum >> 4);
      e2 = exp + XW'(1);
    end
    word = '0;
    cc   = 4'b0000;
    wr   = 1'b1;
    case (kind)
      K_DIVZ: begin
        cc[CC_C] = 1'b1;
        cc[CC_V] = 1'b1;
        wr       = 1'b0;
      end
      K_ZERO: ;
      default: begin
        if (e2 < $signed(XW'(0))) begin
          cc[CC_V] = 1'b1;
        end else if (e2 > EMAX_S) begin
          word     = {sgn, {(W-1){1'b1}}};
          cc[CC_V] = 1'b1;
          cc[CC_L] = sgn;
          cc[CC_G] = ~sgn;
        end else begin
          word     = {sgn, e2[EXP_W-1:0], f2};
          cc[CC_L] = sgn;
          cc[CC_G] = ~sgn;
        end
      end
    endcase
  end

endmodule

// File: rtl/hexdiv_fp_divider.sv
module hexdiv_fp_divider
  import hexdiv_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAC_W+EXP_W:0] dividend,
  input  logic [FRAC_W+EXP_W:0] divisor,
  input  logic                  round_en,
  output logic [FRAC_W+EXP_W:0] quotient,
  output logic [3:0]            cc,
  output logic                  wr_en,
  output logic                  done
);
  localparam int W       = FRAC_W + EXP_W + 1;
  localparam int DIGITS  = FRAC_W / 4;
  localparam int REM_W   = FRAC_W + 4;
  localparam int XW      = EXP_W + 3;
  localparam int CW      = $clog2(DIGITS);
  localparam int BIAS    = 1 << (EXP_W - 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] BIAS_S = XW'(BIAS);
  localparam logic signed [XW-1:0] EMAX_S = XW'(EXP_MAX);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // Operand unpack
  logic                 sa, sb, za, zb;
  logic signed [XW-1:0] ea, eb;
  logic [FRAC_W-1:0]    fa, fb;

  hexdiv_unpack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) u_unp_a (
    .word(dividend), .sgn(sa), .exp(ea), .frac(fa), .is_zero(za));
  hexdiv_unpack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) u_unp_b (
    .word(divisor), .sgn(sb), .exp(eb), .frac(fb), .is_zero(zb));

  // Issue-time exponent and pre-adjust
  logic                 fa_lt;
  logic signed [XW-1:0] qe_raw, qe_adj, qe_start;
  logic                 go_sub;
  always_comb begin
    fa_lt    = (fa < fb);
    qe_raw   = ea - eb + BIAS_S;
    qe_adj   = fa_lt ? qe_raw : qe_raw + XW'(1);
    qe_start = (qe_raw < $signed(XW'(0)) || qe_raw > EMAX_S) ? qe_raw : qe_adj;
    go_sub   = (qe_start >= $signed(XW'(0))) && (qe_start <= EMAX_S);
  end

  // State
  div_state_e           st_q, st_d;
  logic [REM_W-1:0]     rem_q, rem_d;
  logic [FRAC_W-1:0]    dsr_q, dsr_d;
  logic [FRAC_W-1:0]    quo_q, quo_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 sgn_q, sgn_d;
  logic signed [XW-1:0] exp_q, exp_d;
  res_kind_e            kind_q, kind_d;
  logic                 rbit_q, rbit_d;
  logic                 rnd_q, rnd_d;

  logic [REM_W-1:0] dsr_ext;
  logic             sub_ok;
  assign dsr_ext = REM_W'(dsr_q);
  assign sub_ok  = (rem_q >= dsr_ext);

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    sgn_d  = sgn_q;
    exp_d  = exp_q;
    kind_d = kind_q;
    rbit_d = rbit_q;
    rnd_d  = rnd_q;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          sgn_d  = sa ^ sb;
          exp_d  = qe_start;
          dsr_d  = fb;
          rem_d  = fa_lt ? {fa, 4'h0} : REM_W'(fa);
          quo_d  = '0;
          cnt_d  = '0;
          rbit_d = 1'b0;
          rnd_d  = round_en;
          if (zb) begin
            kind_d = K_DIVZ;
            st_d   = S_FIN;
          end else if (za) begin
            kind_d = K_ZERO;
            st_d   = S_FIN;
          end else begin
            kind_d = K_NORM;
            st_d   = go_sub ? S_SUB : S_FIN;
          end
        end
      end
      S_SUB: begin
        if (sub_ok) begin
          rem_d = rem_q - dsr_ext;
          quo_d = quo_q + FRAC_W'(1);
        end else if (cnt_q == CW'(DIGITS - 1)) begin
          rbit_d = ({rem_q, 1'b0} >= {1'b0, dsr_ext});
          st_d   = S_FIN;
        end else begin
          rem_d = rem_q << 4;
          quo_d = quo_q << 4;
          cnt_d = cnt_q + CW'(1);
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      sgn_q  <= 1'b0;
      exp_q  <= '0;
      kind_q <= K_NORM;
      rbit_q <= 1'b0;
      rnd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      dsr_q  <= dsr_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      sgn_q  <= sgn_d;
      exp_q  <= exp_d;
      kind_q <= kind_d;
      rbit_q <= rbit_d;
      rnd_q  <= rnd_d;
    end
  end

  // Result packing
  logic [W-1:0] pk_word;
  logic [3:0]   pk_cc;
  logic         pk_wr;

  hexdiv_pack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) u_pack (
    .kind(kind_q), .sgn(sgn_q), .exp(exp_q), .frac(quo_q),
    .rnd_inc(rbit_q & rnd_q), .word(pk_word), .cc(pk_cc), .wr(pk_wr));

  // Output registers
  logic out_en;
  assign out_en = (st_q == S_FIN);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      quotient <= '0;
      cc       <= 4'b0000;
    end else if (out_en) begin
      quotient <= pk_word;
      cc       <= pk_cc;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done  <= 1'b0;
      wr_en <= 1'b0;
    end else begin
      done  <= out_en;
      wr_en <= out_en & pk_wr;
    end
  end

  // Assertions
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

  a_r8_wr_with_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en |-> done);

  a_r1_div_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == S_IDLE && start && divisor[FRAC_W-1:0] == '0)
      |=> ##1 (done && !wr_en && cc == 4'b1100));

  a_r3_digit_bound: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == S_SUB) |-> (rem_q < {dsr_q, 4'h0}));

  a_r3_sign_code: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && wr_en && !cc[CC_V] && (cc[CC_G] || cc[CC_L]))
      |-> (cc[CC_L] == quotient[W-1] && cc[CC_G] == !quotient[W-1]));

  a_r7_normalized: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && wr_en && !cc[CC_V] && (cc[CC_G] || cc[CC_L]))
      |-> (quotient[FRAC_W-1 -: 4] != 4'h0));

  a_r5_overflow_word: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && wr_en && cc[CC_V] && (cc[CC_G] || cc[CC_L]))
      |-> (quotient[W-2:0] == '1));

  a_r4_underflow_word: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && wr_en && cc == 4'b0100) |-> (quotient == '0));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == S_SUB) |=> $stable(dsr_q));

endmodule

// File: tb/hexdiv_fp_divider_bench.sv
`timescale 1ns/1ps
module hexdiv_fp_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] dividend, divisor;
  logic        round_en;
  logic [31:0] quotient;
  logic [3:0]  cc;
  logic        wr_en, done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hexdiv_fp_divider u_hexdiv_fp_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .round_en(round_en), .quotient(quotient),
    .cc(cc), .wr_en(wr_en), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Arithmetic reference built from the requirements
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input bit rnd, output logic [31:0] q,
                                output logic [3:0] c, output bit w,
                                output string req);
    longint fa, fb, num, qq, rr;
    int     ea, eb, e;
    bit     s;
    fa = longint'(a[23:0]);
    fb = longint'(b[23:0]);
    ea = int'(a[30:24]);
    eb = int'(b[30:24]);
    q = 32'h0; c = 4'b0000; w = 1'b1; req = "R3";
    if (fb == 0) begin w = 1'b0; c = 4'b1100; req = "R1"; return; end
    if (fa == 0) begin req = "R2"; return; end
    while (fa < 64'h100000) begin fa = fa * 16; ea = ea - 1; end
    while (fb < 64'h100000) begin fb = fb * 16; eb = eb - 1; end
    s = a[31] ^ b[31];
    e = ea - eb + 64;
    num = 0;
    if (e >= 0 && e <= 127) begin
      if (fa < fb) num = fa * 16;
      else begin num = fa; e = e + 1; end
    end
    if (e < 0) begin c = 4'b0100; req = "R4"; return; end
    if (e > 127) begin
      q = {s, 31'h7FFFFFFF}; c = s ? 4'b0101 : 4'b0110; req = "R5"; return;
    end
    qq = (num << 20) / fb;
    rr = (num << 20) - qq * fb;
    if (rnd && 2 * rr >= fb) begin
      qq = qq + 1; req = "R6";
      if (qq == (64'h1 << 24)) begin qq = qq >> 4; e = e + 1; end
    end
    if (e > 127) begin
      q = {s, 31'h7FFFFFFF}; c = s ? 4'b0101 : 4'b0110; req = "R5"; return;
    end
    q = {s, 7'(e), 24'(qq)};
    c = s ? 4'b0001 : 4'b0010;
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit rnd);
    dividend = a; divisor = b; round_en = rnd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_and_check(input logic [31:0] a, input logic [31:0] b,
                                 input bit rnd);
    logic [31:0] eq;
    logic [3:0]  ec;
    bit          ew;
    string       req;
    int          lat;
    model(a, b, rnd, eq, ec, ew, req);
    lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    if (!done) begin
      chk(1'b0, "R8", "done never arrived", 32'(lat), 32'd100);
      return;
    end
    chk(lat <= 100, "R8", "latency", 32'(lat), 32'd100);
    chk(quotient == eq, req, "quotient", quotient, eq);
    chk(cc == ec, req, "cc", 32'(cc), 32'(ec));
    chk(wr_en == ew, req, "wr_en", 32'(wr_en), 32'(ew));
    @(negedge clk);
    chk(!done && !wr_en, "R8", "done width", 32'(done), 32'd0);
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit rnd);
    issue(a, b, rnd);
    await_and_check(a, b, rnd);
  endtask

  initial begin
    #(20ns * 190000);
    chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [23:0] fl [8];
    fl[0] = 24'h000000; fl[1] = 24'h000001; fl[2] = 24'h00000F; fl[3] = 24'h100000;
    fl[4] = 24'h7FFFFF; fl[5] = 24'h800000; fl[6] = 24'hABCDEF; fl[7] = 24'hFFFFFF;

    rst_n = 1'b0; start = 1'b0; dividend = '0; divisor = '0; round_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(quotient == 32'h0, "R10", "quotient in reset", quotient, 32'h0);
    chk(cc == 4'h0, "R10", "cc in reset", 32'(cc), 32'h0);
    chk(!done, "R10", "done in reset", 32'(done), 32'h0);
    chk(!wr_en, "R10", "wr_en in reset", 32'(wr_en), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners: R1 divide by zero, R2 zero dividend, R4/R5 range
    run_op(32'h41100000, 32'h42000000, 1'b0);
    run_op(32'hC2000000, 32'h41300000, 1'b1);
    run_op(32'h00100000, 32'h7F100000, 1'b0);
    run_op(32'h7F100000, 32'h00100000, 1'b0);
    run_op(32'hBF200000, 32'h40100000, 1'b0);
    run_op(32'h41300000, 32'h41100000, 1'b1);
    run_op(32'h41100000, 32'h41300000, 1'b1);

    // Fraction pattern sweep (R3, R6, R7)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int r = 0; r < 2; r++)
          run_op({1'(i & 1), 7'(64 + i), fl[i]},
                 {1'((j >> 1) & 1), 7'(64 - j), fl[j]}, 1'(r));

    // Exponent sweep (R3, R4, R5)
    for (int ea = 0; ea < 128; ea += 7)
      for (int eb = 0; eb < 128; eb += 9)
        run_op({1'b0, 7'(ea), 24'h123456}, {1'b1, 7'(eb), 24'h0FEDCB}, 1'(ea & 1));

    // Random operands
    for (int k = 0; k < 300; k++)
      run_op($urandom, $urandom, 1'($urandom & 1));

    // R9: start while busy is ignored
    issue(32'h41FFFFFF, 32'h41100000, 1'b0);
    repeat (3) @(negedge clk);
    issue(32'h00000000, 32'h00000000, 1'b1);
    await_and_check(32'h41FFFFFF, 32'h41100000, 1'b0);
    repeat (5) @(negedge clk);
    chk(!done, "R9", "no second done", 32'(done), 32'h0);

    finish_run();
  end

endmodule